// File: doc/BRIEF.md
# Slow-Clock System Timer

This block is a register-mapped system timer that runs in the bus clock domain and advances on a one-cycle slow-clock enable that pulses at 32768 Hz. A programmable prescaler divides those ticks down to drive a wrapping real-time counter. An absolute alarm comparator watches that counter. A separate periodic interval counter counts raw slow ticks. A watchdog overflow pulse from outside is also captured.

Each event sets a bit in a status register that clears when it is read. A mask register, changed only through separate write-one-to-set and write-one-to-clear addresses, selects which status bits drive the single shared interrupt line. Software uses the alarm for one-shot deadlines, the periodic bit for a fixed tick, and the counter as a continuous time base.

Word addresses: 0 status (read, clears), 1 mask set (write), 2 mask clear (write), 3 mask (read), 4 prescale (read/write), 5 period (read/write), 6 alarm (read/write), 7 counter (read). Status and mask bit positions: periodic = bit 0, watchdog = bit 1, counter increment = bit 2, alarm = bit 3.

Top module: `slowtick_timer`

## Requirements
- R1: After reset, status, mask, counter, period and alarm all read 0, prescale reads 32768, and irq is low.
- R2: The counter advances by one each time PRESCALE slow ticks have elapsed. A prescale of 1 advances it on every tick. A write to address 4 loads the prescale and restarts both the counter and the prescaler phase from 0.
- R3: The counter is CNT_W bits wide (20 by default) and wraps from its all-ones value to 0.
- R4: A read at address 7 returns the counter, zero-extended to the 32-bit data bus.
- R5: Status bit 3 (alarm) sets only on the increment that makes the counter equal to the alarm register. If the alarm is written with the counter's current value, there is no match until the counter has gone through a full wrap.
- R6: When the period register is nonzero, status bit 0 sets each time that many slow ticks have elapsed, and the count reloads on its own. A period of 0 stops it. A write to address 5 restarts its phase.
- R7: Status bit 2 sets on every counter increment.
- R8: A one-cycle pulse on wdog_ovf sets status bit 1.
- R9: A read at address 0 returns the pending status bits and clears all of them. An event that arrives in the same cycle as that read leaves its bit set.
- R10: Writing address 1 sets each mask bit whose data bit is 1, and writing address 2 clears each mask bit whose data bit is 1. Data bits of 0 leave the mask unchanged. Address 3 returns the mask.
- R11: irq is high exactly when some status bit and its mask bit are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle enable at the 32768 Hz rate |
| wdog_ovf | input | 1 | Watchdog overflow event pulse |
| addr | input | ADDR_W | Register word address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, combinational from addr |
| irq | output | 1 | Shared interrupt line |

## Verification
The counter, the status bits, the mask and the programmed registers all change on the same rising edge that samples a tick, a pulse or a write strobe. Read data is combinational in the cycle of the read, while the clear-on-read takes effect at the closing edge of that cycle. irq follows status and mask with no further delay. The bench therefore drives every strobe at a falling edge and removes it at the next one, captures read data just after driving the read, and compares everything else at the following falling edge. This places each comparison half a cycle after the edge that produced the result, so the result has always arrived. The collision case drives a tick and a status read in the same cycle and then reads again, to show which bit survived.

// File: rtl/st_pkg.sv
package st_pkg;
  localparam int N_SRC = 4;
  localparam int BIT_PIT = 0;
  localparam int BIT_WDG = 1;
  localparam int BIT_INC = 2;
  localparam int BIT_ALM = 3;

  typedef enum logic [2:0] {
    A_STATUS = 3'd0,
    A_MSET   = 3'd1,
    A_MCLR   = 3'd2,
    A_MASK   = 3'd3,
    A_PRESC  = 3'd4,
    A_PERIOD = 3'd5,
    A_ALARM  = 3'd6,
    A_COUNT  = 3'd7
  } st_addr_e;
endpackage

// File: rtl/st_rtc.sv
module st_rtc #(
  parameter int CNT_W = 20,
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [PRE_W-1:0] presc,
  input  logic [CNT_W-1:0] alarm,
  output logic [CNT_W-1:0] count,
  output logic             inc_evt,
  output logic             alm_evt
);
  logic [PRE_W-1:0] phase_q;
  logic             phase_hit;

  // The last phase of a prescale window is presc-1. A prescale of 0 wraps to the full range.
  function automatic logic [PRE_W-1:0] last_phase(input logic [PRE_W-1:0] p);
    return p - PRE_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  assign phase_hit = (phase_q == last_phase(presc));
  assign inc_evt   = tick && phase_hit && !restart;
  assign alm_evt   = inc_evt && (step_count(count) == alarm);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      phase_q <= '0;
      count   <= '0;
    end else if (tick) begin
      if (phase_hit) begin
        phase_q <= '0;
        count   <= step_count(count);
      end else begin
        phase_q <= phase_q + PRE_W'(1);
      end
    end
  end

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    inc_evt |=> count == CNT_W'($past(count) + 1'b1));
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(count));
  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_evt && count == '1) |=> count == '0);
  assert_alarm_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    alm_evt |=> count == $past(alarm));
endmodule

// File: rtl/st_pit.sv
module st_pit #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [PER_W-1:0] period,
  output logic             pit_evt
);
  logic [PER_W-1:0] elapsed_q;
  logic             active;
  logic             last_tick;

  function automatic logic at_end(input logic [PER_W-1:0] e, input logic [PER_W-1:0] p);
    return e == (p - PER_W'(1));
  endfunction

  assign active    = (period != '0);
  assign last_tick = active && at_end(elapsed_q, period);
  assign pit_evt   = tick && last_tick && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !active) begin
      elapsed_q <= '0;
    end else if (tick) begin
      elapsed_q <= last_tick ? '0 : elapsed_q + PER_W'(1);
    end
  end

  assert_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (period == '0) |-> !pit_evt);
  assert_needs_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pit_evt |-> tick);
endmodule

// File: rtl/st_irq.sv
module st_irq #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         rd_clr,
  input  logic [N-1:0] set_m,
  input  logic [N-1:0] clr_m,
  output logic [N-1:0] status,
  output logic [N-1:0] mask,
  output logic         irq
);
  function automatic logic [N-1:0] next_status(input logic [N-1:0] s, input logic c,
                                               input logic [N-1:0] e);
    return (c ? '0 : s) | e;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      mask   <= '0;
    end else begin
      status <= next_status(status, rd_clr, evt);
      mask   <= (mask | set_m) & ~clr_m;
    end
  end

  assign irq = |(status & mask);

  assert_event_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> (status & $past(evt)) == $past(evt));
  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |=> (status & ~$past(evt)) == '0);
  assert_mask_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (set_m != '0 && clr_m == '0) |=> (mask & $past(set_m)) == $past(set_m));
  assert_mask_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (set_m == '0 && clr_m == '0) |=> $stable(mask));
endmodule

// File: rtl/slowtick_timer.sv
module slowtick_timer #(
  parameter int CNT_W   = 20,
  parameter int PRE_W   = 16,
  parameter int PER_W   = 16,
  parameter int PRE_RST = 32768,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              wdog_ovf,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  import st_pkg::*;

  localparam int N = N_SRC;

  logic [PRE_W-1:0] presc_q;
  logic [PER_W-1:0] period_q;
  logic [CNT_W-1:0] alarm_q;
  logic [CNT_W-1:0] count;
  logic [N-1:0]     status, mask, evt, set_m, clr_m;
  logic             inc_evt, alm_evt, pit_evt;
  logic             wr_presc, wr_period, wr_alarm, rd_status;
  logic             unused_wdata;
  st_addr_e         a;

  assign a         = st_addr_e'(addr[2:0]);
  assign wr_presc  = wr_en && (a == A_PRESC);
  assign wr_period = wr_en && (a == A_PERIOD);
  assign wr_alarm  = wr_en && (a == A_ALARM);
  assign rd_status = rd_en && (a == A_STATUS);
  assign set_m     = (wr_en && a == A_MSET) ? wdata[N-1:0] : '0;
  assign clr_m     = (wr_en && a == A_MCLR) ? wdata[N-1:0] : '0;
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc_q  <= PRE_W'(PRE_RST);
      period_q <= '0;
      alarm_q  <= '0;
    end else begin
      if (wr_presc)  presc_q  <= wdata[PRE_W-1:0];
      if (wr_period) period_q <= wdata[PER_W-1:0];
      if (wr_alarm)  alarm_q  <= wdata[CNT_W-1:0];
    end
  end

  st_rtc #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_rtc (
    .clk(clk), .rst_n(rst_n), .tick(slow_tick), .restart(wr_presc),
    .presc(presc_q), .alarm(alarm_q), .count(count),
    .inc_evt(inc_evt), .alm_evt(alm_evt)
  );

  st_pit #(.PER_W(PER_W)) u_pit (
    .clk(clk), .rst_n(rst_n), .tick(slow_tick), .restart(wr_period),
    .period(period_q), .pit_evt(pit_evt)
  );

  always_comb begin
    evt = '0;
    evt[BIT_PIT] = pit_evt;
    evt[BIT_WDG] = wdog_ovf;
    evt[BIT_INC] = inc_evt;
    evt[BIT_ALM] = alm_evt;
  end

  st_irq #(.N(N)) u_irq (
    .clk(clk), .rst_n(rst_n), .evt(evt), .rd_clr(rd_status),
    .set_m(set_m), .clr_m(clr_m), .status(status), .mask(mask), .irq(irq)
  );

  always_comb begin
    case (a)
      A_STATUS: rdata = DATA_W'(status);
      A_MASK:   rdata = DATA_W'(mask);
      A_PRESC:  rdata = DATA_W'(presc_q);
      A_PERIOD: rdata = DATA_W'(period_q);
      A_ALARM:  rdata = DATA_W'(alarm_q);
      A_COUNT:  rdata = DATA_W'(count);
      default:  rdata = '0;
    endcase
  end

  assert_wdog_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_ovf |=> status[BIT_WDG]);
  assert_inc_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inc_evt |=> status[BIT_INC]);
  assert_irq_needs_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);
  assert_count_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (a == A_COUNT) |-> (rdata >> CNT_W) == '0);
endmodule

// File: tb/slowtick_timer_bench.sv
module slowtick_timer_bench;
  localparam int CW = 12;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slow_tick = 1'b0, wdog_ovf = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;
  int checks = 0, failures = 0;
  bit reported = 0;

  always #4 clk = ~clk;

  slowtick_timer #(.CNT_W(CW)) u_slowtick_timer (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wdog_ovf(wdog_ovf),
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slow_tick = 1'b1;
      @(negedge clk); slow_tick = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(3'd0, d); check("R1 status", d, 0);
    rd(3'd3, d); check("R1 mask", d, 0);
    rd(3'd4, d); check("R1 prescale", d, 32768);
    rd(3'd5, d); check("R1 period", d, 0);
    rd(3'd6, d); check("R1 alarm", d, 0);
    rd(3'd7, d); check("R1 count", d, 0);
    check("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_prescale();
    logic [31:0] d;
    ticks(3); rd(3'd7, d); check("R2 default prescale holds", d, 0);
    wr(3'd4, 1); ticks(5); rd(3'd7, d); check("R2 R4 prescale 1", d, 5);
    wr(3'd4, 3); rd(3'd7, d); check("R2 restart on write", d, 0);
    ticks(7); rd(3'd7, d); check("R2 prescale 3", d, 2);
  endtask

  task automatic t_status();
    logic [31:0] d;
    rd(3'd0, d);
    ticks(3); rd(3'd0, d); check("R7 increment flag", d, 4);
    rd(3'd0, d); check("R9 cleared by read", d, 0);
    @(negedge clk); wdog_ovf = 1'b1; @(negedge clk); wdog_ovf = 1'b0;
    rd(3'd0, d); check("R8 watchdog flag", d, 2);
  endtask

  task automatic t_periodic();
    logic [31:0] d;
    wr(3'd4, 1); wr(3'd5, 4); rd(3'd0, d);
    ticks(3); rd(3'd0, d); check("R6 before period", d & 1, 0);
    ticks(1); rd(3'd0, d); check("R6 first period", d & 1, 1);
    ticks(4); rd(3'd0, d); check("R6 reload", d & 1, 1);
    ticks(3); rd(3'd0, d); check("R6 mid period", d & 1, 0);
    wr(3'd5, 0); rd(3'd0, d);
    ticks(10); rd(3'd0, d); check("R6 period zero off", d & 1, 0);
  endtask

  task automatic t_alarm();
    logic [31:0] d;
    wr(3'd4, 1); wr(3'd6, 5); rd(3'd0, d);
    ticks(4); rd(3'd0, d); check("R5 no early alarm", d & 8, 0);
    ticks(1); rd(3'd0, d); check("R5 alarm on match", d & 8, 8);
    rd(3'd7, d); check("R5 count at alarm", d, 5);
    wr(3'd6, 5); rd(3'd0, d);
    ticks(10); rd(3'd0, d); check("R5 same value no match", d & 8, 0);
    ticks(4085); rd(3'd0, d); check("R5 no match before wrap", d & 8, 0);
    rd(3'd7, d); check("R3 wrapped count", d, 4);
    ticks(1); rd(3'd0, d); check("R5 match after full wrap", d & 8, 8);
    wr(3'd4, 1); ticks(4095); rd(3'd7, d); check("R3 all ones", d, 4095);
    ticks(1); rd(3'd7, d); check("R3 wrap to zero", d, 0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    rd(3'd0, d); ticks(1);
    @(negedge clk); check("R11 masked off", {31'd0, irq}, 0);
    wr(3'd1, 4); @(negedge clk); check("R11 irq raised", {31'd0, irq}, 1);
    rd(3'd3, d); check("R10 mask set", d, 4);
    wr(3'd1, 1); rd(3'd3, d); check("R10 zero bits keep", d, 5);
    wr(3'd2, 4); rd(3'd3, d); check("R10 mask clear", d, 1);
    @(negedge clk); check("R11 irq dropped", {31'd0, irq}, 0);
    wr(3'd2, 0); rd(3'd3, d); check("R10 zero clear no effect", d, 1);
    wr(3'd2, 1);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    rd(3'd0, d);
    @(negedge clk); wdog_ovf = 1'b1; @(negedge clk); wdog_ovf = 1'b0;
    @(negedge clk); addr = 3'd0; rd_en = 1'b1; slow_tick = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0; slow_tick = 1'b0;
    check("R9 read value", d, 2);
    rd(3'd0, d); check("R9 event beats clear", d, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_prescale();
    t_status();
    t_periodic();
    t_alarm();
    t_mask();
    t_collide();
    if (!reported) begin
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!reported) begin
      reported = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
    $finish;
  end
endmodule